// File: doc/BRIEF.md
# Channel-List Conversion Sequencer

This block is the digital front end of a multiplexed analog acquisition path. Software fills a 16-entry channel list over a small register bus. Each 8-bit entry names an input channel, a gain code, a unipolar flag and a differential flag. A trigger then makes the sequencer take the next entry and drive it onto the mux and amplifier control outputs. It raises a request to the external converter and, when the converter reports done, stores the 12-bit sample in a 16-entry result FIFO.

The trigger source is chosen in control register 1: off, software, a scan tick, or an edge on an external trigger line. In software mode, any bus read of address 0x00 fires one conversion. In one-shot list mode each conversion consumes its entry. In continuous mode a cursor walks the list and wraps back to the first entry, so the list is kept. When a sample is read it is returned in offset binary, with the top bit flipped. Control register 2 holds one enable bit for each FIFO, and writing either bit as zero empties that FIFO.

Top module: `adc_seq`

## Requirements
- R1: After reset, conv_req is low, status (read at 0x04) is 0x0004 (result FIFO empty, nothing else set), and both FIFOs are disabled.
- R2: When a conversion starts, the outputs take their values from the list entry: mux_chan = bits 3:0, amp_gain = bits 5:4, in_unipolar = bit 6, in_diff = bit 7. They hold steady while conv_req is high.
- R3: Control register 1 (write at 0x00) bits 1:0 set the trigger: 00 off, 01 software, 10 scan, 11 external. In software mode, a bus read of 0x00 raises conv_req on the next clock. In mode 00 the same read starts nothing.
- R4: A read of 0x10 pops the oldest sample and returns it as {4'b0, sample XOR 0x800}, in conversion order. A read of 0x10 while the FIFO is empty returns 0.
- R5: Status at 0x04: bit 4 result FIFO full (16), bit 3 at least 8 samples, bit 2 result FIFO empty, bit 1 list full (16), bit 0 conversion busy. The other bits are 0.
- R6: Control register 2 (write at 0x02): bit 10 enables the result FIFO and bit 9 enables the channel list. Writing either bit as 0 empties that FIFO, and list writes at 0x10 are ignored while the list is disabled.
- R7: Control register 1 bit 2 selects continuous mode. In this mode successive conversions step through the list and wrap from the last entry to the first, without removing entries. With bit 2 clear, each conversion removes its entry.
- R8: A trigger that arrives while a conversion is busy, or while the list is empty, is ignored and consumes no entry. conv_req drops in the cycle after conv_done is seen.
- R9: A sample that completes while the result FIFO holds 16 samples is dropped, and the stored samples are unchanged.
- R10: In external mode, an edge on ext_trig starts a conversion: a rising edge when control register 1 bit 3 is 0, a falling edge when it is 1. In scan mode, a scan_tick pulse starts one. Neither input has any effect in software mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| scan_tick | input | 1 | Scan-rate trigger pulse |
| ext_trig | input | 1 | External trigger line |
| conv_req | output | 1 | Conversion request to the converter |
| conv_done | input | 1 | Converter finished, conv_data valid |
| conv_data | input | 12 | Converter sample |
| mux_chan | output | 4 | Selected input channel |
| amp_gain | output | 2 | Amplifier gain code |
| in_unipolar | output | 1 | Unipolar input range |
| in_diff | output | 1 | Differential input |

## Verification
Read data and status are combinational from the registered state, so they are sampled during the cycle of the read strobe. conv_req and the mux outputs become valid one clock after the edge that takes the trigger, whether that trigger is a start read, a scan tick or an ext_trig transition. A sample can be read one clock after the edge that sees conv_done. The bench drives every input at the falling edge and samples outputs at the next falling edge, a full registered step later. Each check is therefore placed exactly one register stage after its stimulus.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 12,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [4:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              scan_tick,
  input  logic              ext_trig,
  output logic              conv_req,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic [3:0]        mux_chan,
  output logic [1:0]        amp_gain,
  output logic              in_unipolar,
  output logic              in_diff
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0]   CNT_ONE  = (PW+1)'(1);
  localparam logic [PW:0]   CNT_FULL = (PW+1)'(DEPTH);
  localparam logic [PW:0]   CNT_HALF = (PW+1)'(DEPTH/2);
  localparam logic [PW-1:0] PTR_ONE  = PW'(1);
  localparam logic [DATA_W-1:0] SIGN_FLIP = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [4:0] A_CTRL1 = 5'h00;
  localparam logic [4:0] A_CTRL2 = 5'h02;
  localparam logic [4:0] A_STAT  = 5'h04;
  localparam logic [4:0] A_FIFO  = 5'h10;

  logic [1:0] trig_mode;
  logic       cont_mode, fall_edge;
  logic       res_en, list_en;
  logic       busy, ext_q;

  logic [7:0]    list_mem [DEPTH];
  logic [PW-1:0] l_rd, l_wr, cur;
  logic [PW:0]   l_cnt;

  logic [DATA_W-1:0] res_mem [DEPTH];
  logic [PW-1:0]     r_rd, r_wr;
  logic [PW:0]       r_cnt;

  logic [7:0] entry_q;

  wire wr_c1   = bus_wr && bus_addr == A_CTRL1;
  wire wr_c2   = bus_wr && bus_addr == A_CTRL2;
  wire wr_list = bus_wr && bus_addr == A_FIFO;
  wire rd_strt = bus_rd && bus_addr == A_CTRL1;
  wire rd_res  = bus_rd && bus_addr == A_FIFO;

  wire ext_edge = fall_edge ? (ext_q & ~ext_trig) : (~ext_q & ext_trig);
  wire trig = (trig_mode == 2'b01 && rd_strt) ||
              (trig_mode == 2'b10 && scan_tick) ||
              (trig_mode == 2'b11 && ext_edge);

  wire l_empty  = l_cnt == '0;
  wire start    = trig && !busy && !l_empty;
  wire l_push   = wr_list && list_en && l_cnt != CNT_FULL;
  wire l_pop    = start && !cont_mode;
  wire l_clr    = wr_c2 && !bus_wdata[9];
  wire [PW-1:0] sel_idx = l_rd + (cont_mode ? cur : '0);

  wire done     = busy && conv_done;
  wire r_push   = done && res_en && r_cnt != CNT_FULL;
  wire r_pop    = rd_res && r_cnt != '0;
  wire r_clr    = wr_c2 && !bus_wdata[10];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_mode <= 2'b00;
      cont_mode <= 1'b0;
      fall_edge <= 1'b0;
      res_en    <= 1'b0;
      list_en   <= 1'b0;
      ext_q     <= 1'b0;
    end else begin
      ext_q <= ext_trig;
      if (wr_c1) begin
        trig_mode <= bus_wdata[1:0];
        cont_mode <= bus_wdata[2];
        fall_edge <= bus_wdata[3];
      end
      if (wr_c2) begin
        res_en  <= bus_wdata[10];
        list_en <= bus_wdata[9];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (l_push) list_mem[l_wr] <= bus_wdata[7:0];
    if (r_push) res_mem[r_wr]  <= conv_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || l_clr) begin
      l_rd  <= '0;
      l_wr  <= '0;
      l_cnt <= '0;
      cur   <= '0;
    end else begin
      if (l_push) l_wr <= l_wr + PTR_ONE;
      if (l_pop)  l_rd <= l_rd + PTR_ONE;
      case ({l_push, l_pop})
        2'b10:   l_cnt <= l_cnt + CNT_ONE;
        2'b01:   l_cnt <= l_cnt - CNT_ONE;
        default: l_cnt <= l_cnt;
      endcase
      if (!cont_mode)
        cur <= '0;
      else if (start)
        cur <= ({1'b0, cur} == l_cnt - CNT_ONE) ? '0 : cur + PTR_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || r_clr) begin
      r_rd  <= '0;
      r_wr  <= '0;
      r_cnt <= '0;
    end else begin
      if (r_push) r_wr <= r_wr + PTR_ONE;
      if (r_pop)  r_rd <= r_rd + PTR_ONE;
      case ({r_push, r_pop})
        2'b10:   r_cnt <= r_cnt + CNT_ONE;
        2'b01:   r_cnt <= r_cnt - CNT_ONE;
        default: r_cnt <= r_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      entry_q <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      entry_q <= list_mem[sel_idx];
    end else if (done) begin
      busy    <= 1'b0;
    end
  end

  assign conv_req    = busy;
  assign mux_chan    = entry_q[3:0];
  assign amp_gain    = entry_q[5:4];
  assign in_unipolar = entry_q[6];
  assign in_diff     = entry_q[7];

  wire [4:0] status = {r_cnt == CNT_FULL, r_cnt >= CNT_HALF, r_cnt == '0,
                       l_cnt == CNT_FULL, busy};
  wire [DATA_W-1:0] sample_out = (r_cnt == '0) ? '0 : res_mem[r_rd] ^ SIGN_FLIP;

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = BUS_W'(status);
      A_FIFO:  bus_rdata = BUS_W'(sample_out);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rd,
  input logic [4:0]  bus_addr,
  input logic [15:0] bus_rdata,
  input logic        scan_tick,
  input logic        ext_trig,
  input logic        conv_req,
  input logic        conv_done,
  input logic [3:0]  mux_chan,
  input logic [1:0]  amp_gain,
  input logic        in_unipolar,
  input logic        in_diff
);
  // R2
  mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> $stable({mux_chan, amp_gain, in_unipolar, in_diff}));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> conv_req);

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_done |=> !conv_req);

  // R3
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> ($past(bus_rd) && $past(bus_addr) == 5'h00) ||
                        $past(scan_tick) || ($past(ext_trig) != $past(ext_trig, 2)));

  // R5
  stat_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 5'h04 |->
      !(bus_rdata[4] && bus_rdata[2]) && (!bus_rdata[4] || bus_rdata[3]) &&
      bus_rdata[15:5] == '0);
endmodule

bind adc_seq adc_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .scan_tick(scan_tick), .ext_trig(ext_trig),
  .conv_req(conv_req), .conv_done(conv_done), .mux_chan(mux_chan),
  .amp_gain(amp_gain), .in_unipolar(in_unipolar), .in_diff(in_diff)
);

// File: tb/adc_seq_tb_top.sv
module adc_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        scan_tick = 1'b0, ext_trig = 1'b0;
  logic        conv_req, conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic [3:0]  mux_chan;
  logic [1:0]  amp_gain;
  logic        in_unipolar, in_diff;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  adc_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .scan_tick(scan_tick), .ext_trig(ext_trig), .conv_req(conv_req),
    .conv_done(conv_done), .conv_data(conv_data), .mux_chan(mux_chan),
    .amp_gain(amp_gain), .in_unipolar(in_unipolar), .in_diff(in_diff)
  );

  // {entry[7:0], sample[11:0], expected readout[11:0]}
  localparam logic [31:0] VEC [4] = '{
    {8'h00, 12'h000, 12'h800},
    {8'hFF, 12'hFFF, 12'h7FF},
    {8'h5A, 12'h800, 12'h000},
    {8'hA3, 12'h123, 12'h923}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic conv(input logic [11:0] s);
    @(negedge clk); conv_done = 1'b1; conv_data = s;
    @(negedge clk); conv_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    brd(5'h04, d);
    check(d == 16'h0004, "R1 status after reset", d, 16'h0004);
    check(conv_req == 1'b0, "R1 conv_req after reset", conv_req, 0);

    bwr(5'h02, 16'h0600);
    bwr(5'h00, 16'h0001);

    for (int i = 0; i < 4; i++) begin
      bwr(5'h10, {8'h00, VEC[i][31:24]});
      brd(5'h00, d);
      check(conv_req == 1'b1, "R3 software start", conv_req, 1);
      check({in_diff, in_unipolar, amp_gain, mux_chan} == VEC[i][31:24],
            "R2 entry fields", {in_diff, in_unipolar, amp_gain, mux_chan}, VEC[i][31:24]);
      conv(VEC[i][23:12]);
      brd(5'h10, d);
      check(d == {4'h0, VEC[i][11:0]}, "R4 offset binary readout", d, VEC[i][11:0]);
    end

    // mode 00: start read has no effect
    bwr(5'h00, 16'h0000);
    bwr(5'h10, 16'h0001);
    brd(5'h00, d);
    check(conv_req == 1'b0, "R3 mode off ignores start", conv_req, 0);

    // busy and empty-list triggers
    bwr(5'h00, 16'h0001);
    bwr(5'h10, 16'h0007);
    brd(5'h00, d);
    check(mux_chan == 4'd1, "R8 first entry", mux_chan, 1);
    brd(5'h00, d);
    brd(5'h04, d);
    check(d == 16'h0005, "R5 busy status", d, 16'h0005);
    conv(12'h111);
    check(conv_req == 1'b0, "R8 req drops after done", conv_req, 0);
    brd(5'h00, d);
    check(conv_req == 1'b1 && mux_chan == 4'd7, "R8 busy trigger consumed nothing", mux_chan, 7);
    conv(12'h222);
    brd(5'h00, d);
    check(conv_req == 1'b0, "R8 empty list ignores start", conv_req, 0);
    brd(5'h10, d);
    check(d == 16'h0911, "R4 order first", d, 16'h0911);
    brd(5'h10, d);
    check(d == 16'h0A22, "R4 order second", d, 16'h0A22);
    brd(5'h10, d);
    check(d == 16'h0000, "R4 empty read", d, 0);

    // continuous mode wrap
    bwr(5'h00, 16'h0005);
    bwr(5'h10, 16'h0001);
    bwr(5'h10, 16'h0002);
    bwr(5'h10, 16'h0003);
    for (int k = 0; k < 4; k++) begin
      brd(5'h00, d);
      check(mux_chan == 4'((k % 3) + 1), "R7 continuous walk", mux_chan, (k % 3) + 1);
      conv(12'(k));
    end
    brd(5'h04, d);
    check(d == 16'h0000, "R7 list kept, four samples", d, 0);

    // enable bits
    bwr(5'h02, 16'h0400);
    brd(5'h00, d);
    check(conv_req == 1'b0, "R6 list cleared", conv_req, 0);
    bwr(5'h10, 16'h0005);
    brd(5'h00, d);
    check(conv_req == 1'b0, "R6 write ignored while disabled", conv_req, 0);
    bwr(5'h02, 16'h0200);
    brd(5'h04, d);
    check(d == 16'h0004, "R6 result FIFO cleared", d, 16'h0004);
    bwr(5'h02, 16'h0600);

    // fill and overflow
    bwr(5'h10, 16'h0004);
    for (int i = 0; i < 17; i++) begin
      brd(5'h00, d);
      conv(12'(i * 5 + 1));
      if (i == 7) begin
        brd(5'h04, d);
        check(d == 16'h0008, "R5 half flag", d, 16'h0008);
      end
    end
    brd(5'h04, d);
    check(d == 16'h0018, "R5 full flag", d, 16'h0018);
    for (int i = 0; i < 16; i++) begin
      brd(5'h10, d);
      check(d == {4'h0, 12'(i * 5 + 1) ^ 12'h800}, "R9 stored samples", d,
            {4'h0, 12'(i * 5 + 1) ^ 12'h800});
    end
    brd(5'h04, d);
    check(d == 16'h0004, "R9 extra sample dropped", d, 16'h0004);

    // external and scan triggers
    bwr(5'h00, 16'h0007);
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk);
    check(conv_req == 1'b1, "R10 rising edge", conv_req, 1);
    conv(12'h000);
    @(negedge clk); ext_trig = 1'b0;
    @(negedge clk);
    check(conv_req == 1'b0, "R10 falling ignored in rising mode", conv_req, 0);
    bwr(5'h00, 16'h000F);
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk);
    check(conv_req == 1'b0, "R10 rising ignored in falling mode", conv_req, 0);
    @(negedge clk); ext_trig = 1'b0;
    @(negedge clk);
    check(conv_req == 1'b1, "R10 falling edge", conv_req, 1);
    conv(12'h000);
    bwr(5'h00, 16'h0006);
    @(negedge clk); scan_tick = 1'b1;
    @(negedge clk); scan_tick = 1'b0;
    check(conv_req == 1'b1, "R10 scan tick", conv_req, 1);
    conv(12'h000);
    bwr(5'h00, 16'h0005);
    @(negedge clk); scan_tick = 1'b1;
    @(negedge clk); scan_tick = 1'b0;
    check(conv_req == 1'b0, "R10 scan ignored in software mode", conv_req, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule